// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block holds the digital tap setting for one lane of an adjustable delay element placed on an input or output path. The setting is a small unsigned number, 0 to 31 with the default width, that selects how many delay steps the lane applies. The block presents that number at all times so that calibration logic can watch it. The analog delay line lies outside the block; only the control state is modelled here.

A build-time parameter selects one of three behaviours. In fixed mode the setting stays at its configured value and the control inputs have no effect. In stepping mode a strobe moves the setting one step up or one step down. In loadable mode the block accepts the same strobes and can also take a new value from a parallel input. Each accepted change raises a busy flag for a fixed number of control-clock cycles. While that flag is high the block drops any new request. A synchronous reset returns the setting to its configured value.

Lanes can be controlled individually, with one instance per lane. They can also be moved in lockstep by driving the control pins of every instance from common logic. The controls are plain strobes sampled on the rising clock edge. There is no valid/ready handshake: the busy output is the only flow control, and a request raised while busy is high is lost rather than held back.

Top module: `dly_tap_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `tap_out` becomes INIT_TAP and `busy` becomes 0 after that edge, whatever the other inputs are and whatever the block was doing.
- R2: In stepping or loadable mode, with `busy` low, `ce`=1, `inc`=1 and no winning load, `tap_out` is one higher after the edge.
- R3: In stepping or loadable mode, with `busy` low, `ce`=1, `inc`=0 and no winning load, `tap_out` is one lower after the edge.
- R4: A step past the top (31) or below the bottom (0) leaves `tap_out` where it is, with no wrap. Such a step still counts as accepted and raises `busy`.
- R5: In loadable mode, with `busy` low and `ld`=1, `tap_out` equals `ld_val` after the edge.
- R6: In loadable mode, when `ld` and `ce` are both high in an accepted cycle, the load wins and `inc` has no effect on the result.
- R7: After the edge that accepts a step or a load, `busy` reads 1 for exactly BUSY_CYC (default 2) cycles and then returns to 0.
- R8: A request (`ce` or `ld`) present at an edge where `busy` is high is ignored: `tap_out` is unchanged after that edge, and the busy window is not extended.
- R9: In fixed mode (MODE=DLY_FIXED), `tap_out` stays at INIT_TAP and `busy` stays 0 whatever `ce`, `inc`, `ld` and `ld_val` do.
- R10: In stepping mode (MODE=DLY_STEP), `ld` and `ld_val` are ignored. A lone `ld` neither changes `tap_out` nor raises `busy`, and a cycle with both `ld` and `ce` acts as a plain step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the configured tap |
| ce | input | 1 | Step strobe; requests one step in the direction given by `inc` |
| inc | input | 1 | Step direction: 1 = up, 0 = down |
| ld | input | 1 | Load strobe (loadable mode only) |
| ld_val | input | TAP_W | Tap value taken on an accepted load |
| tap_out | output | TAP_W | Current tap setting |
| busy | output | 1 | High while an accepted change is settling; requests are dropped |

## Verification
The two functions that can meet in one cycle are the parallel load and the up/down step. The bench provokes this by raising `ld` together with `ce` and `inc`=1 at an idle edge, using a load value that differs from the current tap plus one. The loadable lane must show the loaded value, while the stepping lane, which sees the same pins, must show a plain step. A second collision holds a step request across the whole busy window: exactly one step must land, and `busy` must fall on schedule.

// File: rtl/dly_tap_pkg.sv
package dly_tap_pkg;

  // Build-time behaviour of a lane
  typedef enum logic [1:0] {
    DLY_FIXED    = 2'd0,
    DLY_STEP     = 2'd1,
    DLY_LOADABLE = 2'd2
  } dly_mode_e;

  // Decoded operation applied to the tap register in one cycle
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2,
    OP_LOAD = 2'd3
  } dly_op_e;

endpackage

// File: rtl/dly_req_decode.sv
module dly_req_decode
  import dly_tap_pkg::*;
#(
  parameter dly_mode_e MODE = DLY_LOADABLE
) (
  input  logic    ce,
  input  logic    inc,
  input  logic    ld,
  input  logic    busy,
  output dly_op_e op
);

  generate
    if (MODE == DLY_FIXED) begin : g_fixed
      // every control input is dropped
      logic unused_ok;
      assign unused_ok = ce ^ inc ^ ld ^ busy;
      assign op = OP_NONE;
    end else if (MODE == DLY_STEP) begin : g_step
      logic unused_ok;
      assign unused_ok = ld;
      always_comb begin
        op = OP_NONE;
        if (!busy && ce) op = inc ? OP_INC : OP_DEC;
      end
    end else begin : g_load
      // load outranks stepping in the same cycle
      always_comb begin
        op = OP_NONE;
        if (!busy) begin
          if (ld)      op = OP_LOAD;
          else if (ce) op = inc ? OP_INC : OP_DEC;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dly_tap_reg.sv
module dly_tap_reg
  import dly_tap_pkg::*;
#(
  parameter int TAP_W    = 5,
  parameter int INIT_TAP = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  dly_op_e          op,
  input  logic [TAP_W-1:0] ld_val,
  output logic [TAP_W-1:0] tap
);

  localparam logic [TAP_W-1:0] TAP_TOP  = '1;
  localparam logic [TAP_W-1:0] TAP_BOT  = '0;
  localparam logic [TAP_W-1:0] TAP_INIT = TAP_W'(INIT_TAP);

  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] tap_d;

  always_comb begin
    tap_d = tap_q;
    unique case (op)
      OP_INC:  if (tap_q != TAP_TOP) tap_d = tap_q + 1'b1;
      OP_DEC:  if (tap_q != TAP_BOT) tap_d = tap_q - 1'b1;
      OP_LOAD: tap_d = ld_val;
      default: tap_d = tap_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tap_q <= TAP_INIT;
    else     tap_q <= tap_d;
  end

  assign tap = tap_q;

endmodule

// File: rtl/dly_busy_timer.sv
module dly_busy_timer #(
  parameter int BUSY_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  generate
    if (BUSY_CYC == 0) begin : g_none
      logic unused_ok;
      assign unused_ok = clk ^ rst ^ start;
      assign busy = 1'b0;
    end else begin : g_cnt
      localparam int CNT_W = $clog2(BUSY_CYC + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start)         cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end

      assign busy = (cnt_q != '0);
    end
  endgenerate

endmodule

// File: rtl/dly_tap_ctrl.sv
module dly_tap_ctrl
  import dly_tap_pkg::*;
#(
  parameter int        TAP_W    = 5,
  parameter int        INIT_TAP = 0,
  parameter int        BUSY_CYC = 2,
  parameter dly_mode_e MODE     = DLY_LOADABLE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             inc,
  input  logic             ld,
  input  logic [TAP_W-1:0] ld_val,
  output logic [TAP_W-1:0] tap_out,
  output logic             busy
);

  dly_op_e op;
  logic    accept;
  logic    busy_w;

  dly_req_decode #(
    .MODE (MODE)
  ) u_decode (
    .ce   (ce),
    .inc  (inc),
    .ld   (ld),
    .busy (busy_w),
    .op   (op)
  );

  assign accept = (op != OP_NONE);

  dly_tap_reg #(
    .TAP_W    (TAP_W),
    .INIT_TAP (INIT_TAP)
  ) u_tap (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .ld_val (ld_val),
    .tap    (tap_out)
  );

  dly_busy_timer #(
    .BUSY_CYC (BUSY_CYC)
  ) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .busy  (busy_w)
  );

  assign busy = busy_w;

endmodule

// File: rtl/dly_tap_ctrl_chk.sv
module dly_tap_ctrl_chk
  import dly_tap_pkg::*;
#(
  parameter int        TAP_W    = 5,
  parameter int        INIT_TAP = 0,
  parameter int        BUSY_CYC = 2,
  parameter dly_mode_e MODE     = DLY_LOADABLE
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             inc,
  input logic             ld,
  input logic [TAP_W-1:0] ld_val,
  input logic [TAP_W-1:0] tap_out,
  input logic             busy
);

  localparam logic [TAP_W-1:0] TOP  = '1;
  localparam logic [TAP_W-1:0] INIT = TAP_W'(INIT_TAP);
  localparam int RUN_W = $clog2(BUSY_CYC + 2);

  logic load_ok;
  logic step_ok;
  logic [RUN_W-1:0] run_q;

  assign load_ok = (MODE == DLY_LOADABLE) && !busy && ld;
  assign step_ok = (MODE != DLY_FIXED) && !busy && ce && !load_ok;

  // consecutive busy cycles seen before the current one
  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  a_r1_reset_init: assert property (@(posedge clk)
    rst |=> (tap_out == INIT) && !busy);

  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    step_ok && inc && (tap_out != TOP) |=> tap_out == TAP_W'($past(tap_out) + 1'b1));

  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    step_ok && !inc && (tap_out != '0) |=> tap_out == TAP_W'($past(tap_out) - 1'b1));

  a_r4_sat_top: assert property (@(posedge clk) disable iff (rst)
    step_ok && inc && (tap_out == TOP) |=> tap_out == TOP);

  a_r4_sat_bottom: assert property (@(posedge clk) disable iff (rst)
    step_ok && !inc && (tap_out == '0) |=> tap_out == '0);

  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> tap_out == $past(ld_val));

  a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
    load_ok && ce && inc |=> tap_out == $past(ld_val));

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(tap_out));

  generate
    if (BUSY_CYC > 0 && MODE != DLY_FIXED) begin : g_busy_chk
      a_r7_busy_start: assert property (@(posedge clk) disable iff (rst)
        (load_ok || step_ok) |=> busy);

      a_r7_busy_max: assert property (@(posedge clk) disable iff (rst)
        busy |-> run_q < RUN_W'(BUSY_CYC));

      a_r7_busy_min: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) && !$past(rst) |-> run_q == RUN_W'(BUSY_CYC));
    end
    if (MODE == DLY_FIXED) begin : g_fixed_chk
      a_r9_fixed_idle: assert property (@(posedge clk) disable iff (rst)
        (ce || ld) |=> !busy && $stable(tap_out));
    end
    if (MODE == DLY_STEP) begin : g_step_chk
      a_r10_load_ignored: assert property (@(posedge clk) disable iff (rst)
        ld && !ce && !busy |=> !busy && $stable(tap_out));
    end
  endgenerate

endmodule

bind dly_tap_ctrl dly_tap_ctrl_chk #(
  .TAP_W    (TAP_W),
  .INIT_TAP (INIT_TAP),
  .BUSY_CYC (BUSY_CYC),
  .MODE     (MODE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .inc     (inc),
  .ld      (ld),
  .ld_val  (ld_val),
  .tap_out (tap_out),
  .busy    (busy)
);

// File: tb/dly_tap_ctrl_bench.sv
module dly_tap_ctrl_bench;
  import dly_tap_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TAP_W      = 5;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce  = 1'b0;
  logic inc = 1'b0;
  logic ld  = 1'b0;
  logic [TAP_W-1:0] ld_val = '0;

  logic [TAP_W-1:0] tap_l, tap_v, tap_f;
  logic busy_l, busy_v, busy_f;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // loadable lane
  dly_tap_ctrl #(.TAP_W(TAP_W), .INIT_TAP(5), .BUSY_CYC(2), .MODE(DLY_LOADABLE)) u_dly_tap_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .inc(inc), .ld(ld), .ld_val(ld_val),
    .tap_out(tap_l), .busy(busy_l));

  // stepping lane on the same control pins
  dly_tap_ctrl #(.TAP_W(TAP_W), .INIT_TAP(30), .BUSY_CYC(2), .MODE(DLY_STEP)) u_dly_tap_ctrl_step (
    .clk(clk), .rst(rst), .ce(ce), .inc(inc), .ld(ld), .ld_val(ld_val),
    .tap_out(tap_v), .busy(busy_v));

  // fixed lane on the same control pins
  dly_tap_ctrl #(.TAP_W(TAP_W), .INIT_TAP(12), .BUSY_CYC(2), .MODE(DLY_FIXED)) u_dly_tap_ctrl_fix (
    .clk(clk), .rst(rst), .ce(ce), .inc(inc), .ld(ld), .ld_val(ld_val),
    .tap_out(tap_f), .busy(busy_f));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // fixed lane must never move or report busy
  task automatic chk_fixed();
    chk("R9", "fixed tap", int'(tap_f), 12);
    chk("R9", "fixed busy", int'(busy_f), 0);
  endtask

  // one-cycle request, result sampled at the following falling edge
  task automatic pulse(input logic c, input logic i, input logic l, input int v);
    @(negedge clk);
    ce = c; inc = i; ld = l; ld_val = TAP_W'(v);
    @(negedge clk);
    ce = 1'b0; inc = 1'b0; ld = 1'b0; ld_val = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "load lane tap", int'(tap_l), 5);
    chk("R1", "load lane busy", int'(busy_l), 0);
    chk("R1", "step lane tap", int'(tap_v), 30);
    chk_fixed();
    rst = 1'b0;
  endtask

  task automatic t_step_up();
    pulse(1'b1, 1'b1, 1'b0, 0);
    chk("R2", "load lane up", int'(tap_l), 6);
    chk("R2", "step lane up", int'(tap_v), 31);
    chk("R7", "busy after step", int'(busy_l), 1);
    chk_fixed();
    settle();
  endtask

  task automatic t_busy_window();
    @(negedge clk);
    ce = 1'b1; inc = 1'b1;
    @(negedge clk);
    chk("R7", "busy cycle 1", int'(busy_l), 1);
    chk("R2", "first step lands", int'(tap_l), 7);
    chk("R4", "top saturation", int'(tap_v), 31);
    chk("R4", "busy at saturation", int'(busy_v), 1);
    @(negedge clk);
    chk("R7", "busy cycle 2", int'(busy_l), 1);
    chk("R8", "held step ignored", int'(tap_l), 7);
    @(negedge clk);
    chk("R7", "busy ends", int'(busy_l), 0);
    chk("R8", "no step while busy", int'(tap_l), 7);
    ce = 1'b0; inc = 1'b0;
    chk_fixed();
    @(negedge clk);
    chk("R8", "window not extended", int'(busy_l), 0);
  endtask

  task automatic t_step_down();
    pulse(1'b1, 1'b0, 1'b0, 0);
    chk("R3", "load lane down", int'(tap_l), 6);
    chk("R3", "step lane down", int'(tap_v), 30);
    settle();
  endtask

  task automatic t_load();
    pulse(1'b0, 1'b0, 1'b1, 0);
    chk("R5", "load zero", int'(tap_l), 0);
    chk("R7", "busy after load", int'(busy_l), 1);
    chk("R10", "step lane ignores load", int'(tap_v), 30);
    chk("R10", "step lane not busy", int'(busy_v), 0);
    chk_fixed();
    settle();
  endtask

  task automatic t_sat_low();
    pulse(1'b1, 1'b0, 1'b0, 0);
    chk("R4", "bottom saturation", int'(tap_l), 0);
    chk("R4", "busy at bottom", int'(busy_l), 1);
    chk("R3", "step lane down", int'(tap_v), 29);
    settle();
  endtask

  task automatic t_priority();
    pulse(1'b1, 1'b1, 1'b1, 20);
    chk("R6", "load beats step", int'(tap_l), 20);
    chk("R10", "step lane plain step", int'(tap_v), 30);
    chk_fixed();
    settle();
  endtask

  task automatic t_load_top();
    pulse(1'b0, 1'b0, 1'b1, 31);
    chk("R5", "load top", int'(tap_l), 31);
    settle();
    pulse(1'b1, 1'b1, 1'b0, 0);
    chk("R4", "inc at top", int'(tap_l), 31);
    chk("R2", "step lane up", int'(tap_v), 31);
    settle();
  endtask

  task automatic t_reset_busy();
    pulse(1'b0, 1'b0, 1'b1, 9);
    chk("R5", "load nine", int'(tap_l), 9);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "reset mid busy tap", int'(tap_l), 5);
    chk("R1", "reset mid busy flag", int'(busy_l), 0);
    chk("R1", "step lane reset", int'(tap_v), 30);
    chk_fixed();
  endtask

  initial begin
    t_reset();
    t_step_up();
    t_busy_window();
    t_step_down();
    t_load();
    t_sat_low();
    t_priority();
    t_load_top();
    t_reset_busy();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule